// File: doc/BRIEF.md
# Variable-Length Instruction Bundle Assembler

This block takes the bytes of an instruction stream one at a time and groups them into whole instructions. Each 16-bit instruction word is built from two bytes, low byte first. The first word of an instruction gives its length, which is one, two or three words. The block collects that many words and offers them as one bundle of up to 48 bits, together with the size in bytes and a flag that marks a failure. Only the word count is worked out. The meaning of the instruction is not.

The input is a valid/ready byte port with a marker on the final byte of a stream. The output is a valid/ready port. An illegal first word fails with a size of 2. So does an instruction cut short by the end of the stream. In both cases the consumer advances by exactly one word. The bytes that were already collected after that word are not thrown away: they stay in the window and become the start of the next instruction. This lets decoding resynchronise on the next word boundary.

Top module: `insn_bundler`

## Requirements
- R1: Bundle bits 15:0 hold the first word, formed as {second byte, first byte} of the instruction.
- R2: The first extension word sits in bundle bits 31:16 and the second in bits 47:32, each again low byte first.
- R3: The word count depends on bits 15:13 of the first word.
  - Value 1 gives one word.
  - Value 0 takes source register bits 3:0 and source mode bits 5:4.
  - Any other value takes source register bits 11:8, source mode bits 5:4, and a destination flag in bit 7 that adds one word.
  - The source adds one word when the mode is 1 and the register is not 3, or when the mode is 3 and the register is 0.
- R4: A complete instruction is offered with out_fail low and out_size equal to twice its word count.
- R5: A first word with source register 0 and source mode 2 is illegal. It is offered with out_fail high, out_size 2 and the first word in bits 15:0. The bytes that follow start the next instruction.
- R6: An instruction that needs more bytes than remain before the end of the stream is offered with out_fail high, out_size 2 and its first word. Any bytes after that word are replayed as the start of the next instruction.
- R7: A single byte left at an instruction boundary at the end of the stream is offered with out_fail high, out_size 0 and a zero bundle. That byte is then dropped.
- R8: Every bundle bit at or above position 8*out_size is zero.
- R9: While out_valid is high and out_ready is low, out_bundle, out_size and out_fail stay unchanged.
- R10: in_ready is low while out_valid is high, so no byte is taken while a bundle is offered.
- R11: Once the bytes of an ended stream are fully drained, in_ready rises again and the next byte starts a new stream.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented |
| in_ready | output | 1 | The block takes the byte this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | The byte is the last of its stream |
| out_valid | output | 1 | A bundle is offered |
| out_ready | input | 1 | The consumer takes the bundle |
| out_bundle | output | 48 | Collected instruction words, upper unused bits zero |
| out_size | output | 3 | Bytes consumed: 0, 2, 4 or 6 |
| out_fail | output | 1 | Illegal, truncated or runt instruction |

## Verification
Two functions can fall in the same cycle.

- **End marker on the completing byte.** The end-of-stream marker can arrive on the very byte that completes an instruction. The block must then judge the instruction complete rather than truncated. The bench provokes this by ending every stream exactly on an instruction's final byte.
- **Replayed window that is already complete.** A truncation failure can leave replayed bytes that already hold a complete instruction while the stream has already ended. The bench provokes this with a short stream whose tail is a one-word instruction followed by a stray byte.

The scoreboard computes its own expected bundles by walking each stream with a byte index. It judges the outputs while out_ready is stalled on a fixed pattern, so that the hold-stable behaviour is checked across the same offers.

// File: rtl/insn_bundler_pkg.sv
package insn_bundler_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 2;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int MAX_WORDS  = 3;
  localparam int WIN_BYTES  = WORD_BYTES * MAX_WORDS;
  localparam int BUNDLE_W   = BYTE_W * WIN_BYTES;
  localparam int CNT_W      = $clog2(WIN_BYTES + 1);

  typedef struct packed {
    logic       illegal;
    logic [1:0] words;
  } len_info_t;

  // One extra word for the source operand?
  function automatic logic src_takes_ext(input logic [3:0] reg_id,
                                         input logic [1:0] mode);
    return ((mode == 2'd1) && (reg_id != 4'd3)) ||
           ((mode == 2'd3) && (reg_id == 4'd0));
  endfunction

  function automatic logic src_is_bad(input logic [3:0] reg_id,
                                      input logic [1:0] mode);
    return (reg_id == 4'd0) && (mode == 2'd2);
  endfunction

  // Word count of an instruction from its leading word.
  function automatic len_info_t measure(input logic [WORD_W-1:0] w);
    len_info_t  r;
    logic [3:0] sreg;
    logic [1:0] smode;
    r.illegal = 1'b0;
    r.words   = 2'd1;
    smode     = w[5:4];
    case (w[15:13])
      3'b001: r.words = 2'd1;
      3'b000: begin
        sreg      = w[3:0];
        r.illegal = src_is_bad(sreg, smode);
        r.words   = 2'd1 + {1'b0, src_takes_ext(sreg, smode)};
      end
      default: begin
        sreg      = w[11:8];
        r.illegal = src_is_bad(sreg, smode);
        r.words   = 2'd1 + {1'b0, src_takes_ext(sreg, smode)} + {1'b0, w[7]};
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/insn_bundler_len.sv
module insn_bundler_len
  import insn_bundler_pkg::*;
(
  input  logic [WORD_W-1:0] head_word,
  output logic              illegal,
  output logic [CNT_W-1:0]  need_bytes
);
  len_info_t info;

  always_comb begin
    info       = measure(head_word);
    illegal    = info.illegal;
    need_bytes = info.illegal ? CNT_W'(WORD_BYTES)
                              : CNT_W'(int'(info.words) * WORD_BYTES);
  end
endmodule

// File: rtl/insn_bundler_window.sv
module insn_bundler_window #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [BYTE_W-1:0]       push_byte,
  input  logic                    pop,
  input  logic [CNT_W-1:0]        pop_count,
  output logic [DEPTH*BYTE_W-1:0] win_flat,
  output logic [CNT_W-1:0]        fill
);
  localparam int WIN_W = DEPTH * BYTE_W;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] fill_q;

  // Slots above the fill level are always zero, so a push can OR in.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (push) begin
      win_q  <= win_q | (WIN_W'(push_byte) << (int'(fill_q) * BYTE_W));
      fill_q <= fill_q + CNT_W'(1);
    end else if (pop) begin
      win_q  <= win_q >> (int'(pop_count) * BYTE_W);
      fill_q <= fill_q - pop_count;
    end
  end

  assign win_flat = win_q;
  assign fill     = fill_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH)); // R10
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> fill_q < CNT_W'(DEPTH)); // R10
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R10
  AST_POP_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pop_count <= fill_q); // R6
endmodule

// File: rtl/insn_bundler_pack.sv
module insn_bundler_pack #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 6,
  parameter int SIZE_W = 3
) (
  input  logic [DEPTH*BYTE_W-1:0] win_flat,
  input  logic [SIZE_W-1:0]       size,
  output logic [DEPTH*BYTE_W-1:0] bundle
);
  // Lanes below the size pass through; the rest read as zero.
  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    localparam logic [SIZE_W-1:0] LANE = SIZE_W'(g);
    assign bundle[g*BYTE_W +: BYTE_W] =
      (LANE < size) ? win_flat[g*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/insn_bundler.sv
module insn_bundler
  import insn_bundler_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                in_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BUNDLE_W-1:0] out_bundle,
  output logic [CNT_W-1:0]    out_size,
  output logic                out_fail
);
  logic [BUNDLE_W-1:0] win_flat;
  logic [CNT_W-1:0]    win_fill;
  logic [CNT_W-1:0]    dec_need;
  logic                dec_illegal;
  logic [CNT_W-1:0]    need_bytes;
  logic [CNT_W-1:0]    drop_count;
  logic                eos_q;

  // Named events
  logic have_word, complete, truncated, runt, accept, emit;

  insn_bundler_len u_len (
    .head_word  (win_flat[WORD_W-1:0]),
    .illegal    (dec_illegal),
    .need_bytes (dec_need)
  );

  always_comb begin
    have_word  = win_fill >= CNT_W'(WORD_BYTES);
    need_bytes = have_word ? dec_need : CNT_W'(WORD_BYTES);
    complete   = have_word && (win_fill >= need_bytes);
    truncated  = eos_q && have_word && !complete;
    runt       = eos_q && (win_fill == CNT_W'(1));
  end

  always_comb begin
    out_valid = complete || truncated || runt;
    out_fail  = truncated || runt || (complete && dec_illegal);
    if (complete)       out_size = need_bytes;
    else if (truncated) out_size = CNT_W'(WORD_BYTES);
    else                out_size = '0;
    drop_count = runt ? CNT_W'(1) : out_size;
  end

  assign in_ready = !eos_q && !complete;
  assign accept   = in_valid && in_ready;
  assign emit     = out_valid && out_ready;

  // The end marker is held until the window has drained.
  always_ff @(posedge clk) begin
    if (!rst_n)                     eos_q <= 1'b0;
    else if (accept && in_last)     eos_q <= 1'b1;
    else if (eos_q && win_fill == '0) eos_q <= 1'b0;
  end

  insn_bundler_window #(
    .BYTE_W (BYTE_W),
    .DEPTH  (WIN_BYTES),
    .CNT_W  (CNT_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_byte (in_byte),
    .pop       (emit),
    .pop_count (drop_count),
    .win_flat  (win_flat),
    .fill      (win_fill)
  );

  insn_bundler_pack #(
    .BYTE_W (BYTE_W),
    .DEPTH  (WIN_BYTES),
    .SIZE_W (CNT_W)
  ) u_pack (
    .win_flat (win_flat),
    .size     (out_size),
    .bundle   (out_bundle)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bundle)
      && $stable(out_size) && $stable(out_fail)); // R9
  AST_NO_TAKE_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10
  AST_OK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fail |-> out_size >= CNT_W'(2) && !out_size[0]); // R4
  AST_FAIL_SIZE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fail |-> out_size <= CNT_W'(2)); // R5
  AST_ZERO_SIZE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_size == '0 |-> out_fail && out_bundle == '0); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bundle >> (int'(out_size) * BYTE_W)) == '0); // R8
  AST_REPLAY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    emit && out_fail && out_size == CNT_W'(2)
      |=> int'(win_fill) == int'($past(win_fill)) - 2); // R6
  AST_DRAIN_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    eos_q && win_fill == '0 |=> in_ready); // R11
endmodule

// File: tb/insn_bundler_tb.sv
module insn_bundler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [47:0] out_bundle;
  logic [2:0]  out_size;
  logic        out_fail;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [47:0] exp_b[$];
  int          exp_s[$];
  bit          exp_f[$];
  string       exp_t[$];

  always #10 clk = ~clk;

  insn_bundler u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_bundle(out_bundle), .out_size(out_size),
    .out_fail(out_fail)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Word count from the R3 rules, written as an operand tally.
  function automatic int bench_len(input logic [15:0] w, output bit bad);
    int n;
    logic [3:0] r;
    logic [1:0] m;
    n = 1;
    bad = 0;
    m = w[5:4];
    if (w[15:13] != 3'b001) begin
      r = (w[15:13] == 3'b000) ? w[3:0] : w[11:8];
      if (r == 4'd0 && m == 2'd2) bad = 1;
      if (m == 2'd1 && r != 4'd3) n = n + 1;
      if (m == 2'd3 && r == 4'd0) n = n + 1;
      if (w[15:13] != 3'b000 && w[7]) n = n + 1;
    end
    return n;
  endfunction

  task automatic expect_item(input logic [47:0] b, input int s, input bit f,
                             input string t);
    exp_b.push_back(b); exp_s.push_back(s); exp_f.push_back(f); exp_t.push_back(t);
  endtask

  // Scoreboard driver: model the stream, then feed its bytes.
  task automatic send_stream(input logic [7:0] s[$]);
    int pos;
    int n;
    pos = 0;
    n = s.size();
    while (pos < n) begin
      if (n - pos == 1) begin
        expect_item('0, 0, 1, "R7");
        pos = n;
      end else begin
        logic [15:0] w;
        bit bad;
        int nw;
        w  = {s[pos+1], s[pos]};
        nw = bench_len(w, bad);
        if (bad) begin
          expect_item({32'h0, w}, 2, 1, "R5");
          pos += 2;
        end else if (n - pos < 2 * nw) begin
          expect_item({32'h0, w}, 2, 1, "R6");
          pos += 2;
        end else begin
          logic [47:0] b;
          b = '0;
          for (int k = 0; k < 2 * nw; k++) b |= 48'(s[pos+k]) << (8 * k);
          expect_item(b, 2 * nw, 0, "R3/R4");
          pos += 2 * nw;
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = s[i]; in_last = (i == n - 1);
      #5;
      while (!in_ready) begin @(negedge clk); #5; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    for (int t = 0; t < 60 && (exp_b.size() != 0 || !in_ready); t++) @(negedge clk);
    #5;
    check(in_ready == 1'b1, "R11 in_ready after drain", 48'(in_ready), 48'd1);
  endtask

  // Monitor: stall pattern on out_ready, stability and scoreboard compare.
  initial begin
    bit          pend;
    logic [47:0] hb;
    logic [2:0]  hs;
    logic        hf;
    pend = 0; hb = '0; hs = '0; hf = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 3) != 0;
      #5;
      if (rst_n) begin
        if (pend)
          check(out_valid && out_bundle == hb && out_size == hs && out_fail == hf,
                "R9 hold while stalled", out_bundle, hb);
        pend = out_valid && !out_ready;
        hb = out_bundle; hs = out_size; hf = out_fail;
        if (out_valid && out_ready) begin
          check(in_ready == 1'b0, "R10 in_ready low during offer", 48'(in_ready), 48'd0);
          if (exp_b.size() == 0) begin
            check(1'b0, "R4 unexpected bundle", out_bundle, '0);
          end else begin
            logic [47:0] eb;
            int es;
            bit ef;
            string et;
            eb = exp_b.pop_front(); es = exp_s.pop_front();
            ef = exp_f.pop_front(); et = exp_t.pop_front();
            check(out_bundle == eb, {et, " R1/R2/R8 bundle"}, out_bundle, eb);
            check(int'(out_size) == es, {et, " size"}, 48'(out_size), 48'(es));
            check(out_fail == ef, {et, " fail flag"}, 48'(out_fail), 48'(ef));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(out_valid == 1'b0, "R12 reset out_valid", 48'(out_valid), 48'd0);
    check(in_ready == 1'b1, "R12 reset in_ready", 48'(in_ready), 48'd1);
    // R1 R2 R3 R4: one, two and three word forms; end marker on completing byte
    send_stream('{8'h12, 8'h3C, 8'h0B, 8'h4A, 8'h95, 8'h54, 8'h11, 8'h11,
                  8'h22, 8'h22, 8'h30, 8'h10, 8'hEF, 8'hBE, 8'h91, 8'h43,
                  8'h42, 8'h00});
    // R5: illegal words in both formats, constant form not illegal
    send_stream('{8'h20, 8'h40, 8'h20, 8'h10, 8'h21, 8'h42, 8'h12, 8'h3C});
    // R6 R7: chained truncation with replay, then a lone byte
    send_stream('{8'h95, 8'h54, 8'h11, 8'h11, 8'h22});
    // R6: replayed bytes already form a complete word, then a stray byte
    send_stream('{8'h95, 8'h54, 8'h12, 8'h3C, 8'h07});
    // R7: single byte stream
    send_stream('{8'h5A});
    // R3: jump format ignores mode bits, symbolic and immediate sources
    send_stream('{8'hF0, 8'h2F, 8'h10, 8'h40, 8'hFE, 8'hCA, 8'hB2, 8'h40,
                  8'h34, 8'h12, 8'h78, 8'h56});
    repeat (10) @(negedge clk);
    check(exp_b.size() == 0, "R4 all bundles delivered", 48'(exp_b.size()), 48'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule